// File: doc/BRIEF.md
# Nested Interrupt Acceptance Controller

This block decides, at each instruction boundary, whether a pending interrupt request may preempt the context that is running now. It handles three kinds of source. The first is one non-maskable request. The second is a software-interrupt request, sampled when the instruction that raises it completes. The third is a vector of maskable sources, and each maskable source carries a one-bit programmable priority: 0 is high and 1 is low.

The controller keeps a global enable flag and an in-service priority flag. It also tracks whether the non-maskable handler is active. On every acknowledge it pushes these three values onto a small context stack, and a return-from-interrupt strobe pops them back. A request that is held back stays latched and is taken later. After a return, the first instruction boundary never grants anything, so one main-program instruction always runs first.

The surrounding core uses the one-cycle acknowledge pulse and the granted source index to fetch the vector. The core also drives the enable-set and enable-clear strobes from its instructions.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Decisions are taken only in a cycle with `insn_done` high. A grant shows on the next cycle as a one-cycle `ack` pulse, with `ack_id` = source index 0..N-1 for maskable sources, N for software and N+1 for non-maskable.
- R2: Every acknowledge clears `ie_flag`, and this overrides enable strobes in the same cycle. If `ei_clr` and `ei_set` arrive together, clear wins. Outside acknowledge and return cycles, `ei_set` sets the flag.
- R3: A maskable source is never granted while `ie_flag` is 0. Its request stays pending.
- R4: Granting a high-priority maskable source sets `isp_flag` to 0. Granting a low-priority maskable source or the software interrupt sets it to 1. A non-maskable grant leaves it unchanged.
- R5: While `isp_flag` is 0, low-priority maskable requests are not granted. High-priority ones with `ie_flag` = 1 are granted.
- R6: The non-maskable request is latched and wins over everything else, regardless of `ie_flag` and `isp_flag`. While its handler is active, nothing is granted, not even another non-maskable request.
- R7: The software interrupt is granted regardless of `ie_flag` and `isp_flag`, except inside the non-maskable context. It ranks below non-maskable and above maskable requests.
- R8: Among eligible maskable requests, high priority beats low priority. Within one priority level, the lowest index wins.
- R9: A maskable request pulse is latched until that source is acknowledged. The latch clears in the grant cycle, unless a new request arrives in that same cycle.
- R10: `reti` restores the enable, in-service and non-maskable-context values saved at the matching acknowledge. If the stack is empty, nothing changes. The first `insn_done` after a `reti` grants nothing.
- R11: An acknowledge with the stack already holding `STK_DEPTH` entries drops the save and sets `stk_ovf`, which stays set until reset.
- R12: Synchronous reset gives `ack`=0, `ie_flag`=0, `isp_flag`=1, `stk_ovf`=0, no pending requests and an empty stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Maskable request pulses, latched |
| irq_prio | input | NUM_SRC | Per-source priority, 0 high, 1 low |
| nmi_req | input | 1 | Non-maskable request pulse, latched |
| swi_req | input | 1 | Software interrupt, sampled with insn_done |
| ei_set | input | 1 | Set the enable flag |
| ei_clr | input | 1 | Clear the enable flag |
| insn_done | input | 1 | Instruction boundary strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| ack | output | 1 | Acknowledge pulse |
| ack_id | output | $clog2(NUM_SRC+2) | Granted source index |
| ie_flag | output | 1 | Global enable flag |
| isp_flag | output | 1 | In-service priority flag |
| stk_ovf | output | 1 | Sticky context stack overflow |

## Verification
Two pairs of functions can meet in one cycle. An acknowledge can coincide with an enable strobe. A return can coincide with an instruction boundary, and the first boundary after a return can coincide with newly pending requests. The bench drives all these strobes from a pseudo-random source at high rates, so every pairing occurs many times. A model built from the requirements judges the result: the acknowledge must win over the enable strobe, and the boundary right after a return must stay silent while the pending latches survive it.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  typedef struct packed {
    logic nmi;
    logic isp;
    logic ie;
  } ctx_t;

  localparam ctx_t CTX_RESET = '{nmi: 1'b0, isp: 1'b1, ie: 1'b0};
endpackage

// File: rtl/irq_first_one.sv
module irq_first_one #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  set,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  pend
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic hit;
    assign hit = clr_en && (clr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (rst) pend[g] <= 1'b0;
      else     pend[g] <= set[g] | (pend[g] & ~hit);
    end
  end
endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack
  import irq_nest_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  ctx_t din,
  output ctx_t top,
  output logic empty,
  output logic ovf
);
  ctx_t          mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_m1;
  logic          full;

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign cnt_m1 = cnt - CW'(1);
  assign top    = mem[cnt_m1[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      cnt <= cnt + CW'(1);
    end else if (pop && !empty) begin
      cnt <= cnt_m1;
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int STK_DEPTH = 4,
  localparam int IDW = $clog2(NUM_SRC + 2),
  localparam int SW  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_prio,
  input  logic               nmi_req,
  input  logic               swi_req,
  input  logic               ei_set,
  input  logic               ei_clr,
  input  logic               insn_done,
  input  logic               reti,
  output logic               ack,
  output logic [IDW-1:0]     ack_id,
  output logic               ie_flag,
  output logic               isp_flag,
  output logic               stk_ovf
);
  localparam logic [IDW-1:0] ID_SWI = IDW'(NUM_SRC);
  localparam logic [IDW-1:0] ID_NMI = IDW'(NUM_SRC + 1);

  ctx_t               ctx_q;
  ctx_t               stk_top;
  logic               stk_empty;
  logic [NUM_SRC-1:0] pend;
  logic               nmi_pend;
  logic               hold_q;
  logic               in_nmi_ctx;

  logic [NUM_SRC-1:0] hp_vec, lp_vec;
  logic               hp_found, lp_found;
  logic [SW-1:0]      hp_idx, lp_idx;

  logic               window;
  logic               g_any, g_nmi, g_swi, g_mask, g_hi;
  logic [SW-1:0]      g_src;
  logic [IDW-1:0]     g_id;

  assign in_nmi_ctx = ctx_q.nmi;
  assign hp_vec     = pend & ~irq_prio;
  assign lp_vec     = pend & irq_prio;

  irq_first_one #(.W(NUM_SRC)) u_hp (.vec(hp_vec), .found(hp_found), .idx(hp_idx));
  irq_first_one #(.W(NUM_SRC)) u_lp (.vec(lp_vec), .found(lp_found), .idx(lp_idx));

  // Acceptance decision
  assign window = insn_done && !reti && !hold_q && !ctx_q.nmi;

  always_comb begin
    g_nmi  = 1'b0;
    g_swi  = 1'b0;
    g_mask = 1'b0;
    g_hi   = 1'b0;
    g_src  = '0;
    if (window) begin
      if (nmi_pend)                               g_nmi = 1'b1;
      else if (swi_req)                           g_swi = 1'b1;
      else if (ctx_q.ie && hp_found)              begin g_mask = 1'b1; g_hi = 1'b1; g_src = hp_idx; end
      else if (ctx_q.ie && ctx_q.isp && lp_found) begin g_mask = 1'b1; g_src = lp_idx; end
    end
  end

  assign g_any = g_nmi | g_swi | g_mask;
  assign g_id  = g_nmi ? ID_NMI : (g_swi ? ID_SWI : IDW'(g_src));

  irq_pend_bank #(.N(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .set(irq_req),
    .clr_en(g_mask), .clr_idx(g_src), .pend(pend)
  );

  irq_ctx_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(g_any), .pop(reti),
    .din(ctx_q), .top(stk_top), .empty(stk_empty), .ovf(stk_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_pend <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      nmi_pend <= nmi_req | (nmi_pend & ~g_nmi);
      if (reti)           hold_q <= 1'b1;
      else if (insn_done) hold_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q <= CTX_RESET;
    end else if (g_any) begin
      ctx_q.ie <= 1'b0;
      if (g_nmi)      ctx_q.nmi <= 1'b1;
      else if (g_swi) begin ctx_q.nmi <= 1'b0; ctx_q.isp <= 1'b1; end
      else            begin ctx_q.nmi <= 1'b0; ctx_q.isp <= ~g_hi; end
    end else if (reti) begin
      if (!stk_empty) ctx_q <= stk_top;
    end else if (ei_clr) begin
      ctx_q.ie <= 1'b0;
    end else if (ei_set) begin
      ctx_q.ie <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack    <= 1'b0;
      ack_id <= '0;
    end else begin
      ack <= g_any;
      if (g_any) ack_id <= g_id;
    end
  end

  assign ie_flag  = ctx_q.ie;
  assign isp_flag = ctx_q.isp;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int NUM_SRC = 8,
  localparam int IDW = $clog2(NUM_SRC + 2)
) (
  input logic           clk,
  input logic           rst,
  input logic           insn_done,
  input logic           reti,
  input logic           ack,
  input logic [IDW-1:0] ack_id,
  input logic           ie_flag,
  input logic           isp_flag,
  input logic           stk_ovf,
  input logic           in_nmi_ctx
);
  a_r1_ack_at_boundary: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(insn_done));

  a_r2_ack_clears_enable: assert property (@(posedge clk) disable iff (rst)
    ack |-> !ie_flag);

  a_r4_swi_low_level: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_id == IDW'(NUM_SRC)) |-> isp_flag);

  a_r6_nmi_blocks_all: assert property (@(posedge clk) disable iff (rst)
    in_nmi_ctx |=> !ack);

  a_r10_quiet_after_reti: assert property (@(posedge clk) disable iff (rst)
    reti |=> !ack);

  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    stk_ovf |=> stk_ovf);
endmodule

bind irq_nest_ctrl irq_nest_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .insn_done(insn_done), .reti(reti),
  .ack(ack), .ack_id(ack_id), .ie_flag(ie_flag), .isp_flag(isp_flag),
  .stk_ovf(stk_ovf), .in_nmi_ctx(in_nmi_ctx)
);

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;
  localparam int N   = 4;
  localparam int D   = 3;
  localparam int IDW = $clog2(N + 2);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   irq_req = '0, irq_prio = '0;
  logic           nmi_req = 0, swi_req = 0, ei_set = 0, ei_clr = 0;
  logic           insn_done = 0, reti = 0;
  logic           ack, ie_flag, isp_flag, stk_ovf;
  logic [IDW-1:0] ack_id;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irq_nest_ctrl #(.NUM_SRC(N), .STK_DEPTH(D)) i_irq_nest_ctrl (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_prio(irq_prio),
    .nmi_req(nmi_req), .swi_req(swi_req), .ei_set(ei_set), .ei_clr(ei_clr),
    .insn_done(insn_done), .reti(reti), .ack(ack), .ack_id(ack_id),
    .ie_flag(ie_flag), .isp_flag(isp_flag), .stk_ovf(stk_ovf)
  );

  // Requirement-level model
  logic [N-1:0] m_pend;
  logic m_nmip, m_ie, m_isp, m_nmi, m_hold, m_ack, m_ovf;
  int   m_id, m_cnt;
  logic [2:0] m_stk [D];
  string m_tag = "R1";

  always @(posedge clk) begin
    int gk, gid;
    logic [N-1:0] hp, lp;
    if (rst) begin
      m_pend = '0; m_nmip = 0; m_ie = 0; m_isp = 1; m_nmi = 0;
      m_hold = 0; m_ack = 0; m_id = 0; m_cnt = 0; m_ovf = 0;
    end else begin
      gk = 0; gid = 0; m_tag = "R1";
      hp = m_pend & ~irq_prio;
      lp = m_pend & irq_prio;
      if (insn_done && !reti && m_hold) m_tag = "R10";
      else if (insn_done && !reti) begin
        if (m_nmi) m_tag = "R6";
        else if (m_nmip) begin gk = 1; gid = N + 1; m_tag = "R6"; end
        else if (swi_req) begin gk = 2; gid = N; m_tag = "R7"; end
        else if (!m_ie) m_tag = "R3";
        else if (hp != 0) begin
          gk = 3; m_tag = "R8";
          for (int i = N - 1; i >= 0; i--) if (hp[i]) gid = i;
        end else if (lp != 0 && m_isp) begin
          gk = 4; m_tag = "R8";
          for (int i = N - 1; i >= 0; i--) if (lp[i]) gid = i;
        end else if (lp != 0) m_tag = "R5";
      end
      if (gk >= 3) m_pend[gid] = 1'b0;
      m_pend = m_pend | irq_req;
      m_nmip = nmi_req | (m_nmip & (gk != 1));
      if (gk != 0) begin
        if (m_cnt == D) m_ovf = 1;
        else begin m_stk[m_cnt] = {m_nmi, m_isp, m_ie}; m_cnt++; end
        m_ie = 0;
        if (gk == 1) m_nmi = 1;
        else begin m_nmi = 0; m_isp = (gk == 4 || gk == 2); end
      end else if (reti) begin
        if (m_cnt > 0) begin m_cnt--; {m_nmi, m_isp, m_ie} = m_stk[m_cnt]; end
      end else if (ei_clr) m_ie = 0;
      else if (ei_set) m_ie = 1;
      if (reti) m_hold = 1; else if (insn_done) m_hold = 0;
      m_ack = (gk != 0);
      if (gk != 0) m_id = gid;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk({m_tag, " ack"}, int'(ack), int'(m_ack));
    if (m_ack) chk({m_tag, " R1 ack_id"}, int'(ack_id), m_id);
    chk("R2 ie_flag", int'(ie_flag), int'(m_ie));
    chk("R4 isp_flag", int'(isp_flag), int'(m_isp));
    chk("R11 stk_ovf", int'(stk_ovf), int'(m_ovf));
  endtask

  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] pr,
                      input logic nm, input logic sw, input logic es,
                      input logic ec, input logic id, input logic rt);
    @(negedge clk);
    compare_all();
    irq_req = rq; irq_prio = pr; nmi_req = nm; swi_req = sw;
    ei_set = es; ei_clr = ec; insn_done = id; reti = rt;
  endtask

  initial begin
    logic [31:0] lf = 32'hACE1_1234;
    logic [N-1:0] pr_hold = '0;
    bit seen_r9 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    chk("R12 ack", int'(ack), 0);
    chk("R12 ie_flag", int'(ie_flag), 0);
    chk("R12 isp_flag", int'(isp_flag), 1);
    chk("R12 stk_ovf", int'(stk_ovf), 0);

    // R9/R3: pulse on source 2 while disabled, held across boundaries
    step(4'b0100, 4'b0000, 0, 0, 0, 0, 1, 0);
    for (int k = 0; k < 4; k++) step('0, '0, 0, 0, 0, 0, 1, 0);
    step('0, '0, 0, 0, 1, 0, 0, 0);
    step('0, '0, 0, 0, 0, 0, 1, 0);
    step('0, '0, 0, 0, 0, 0, 0, 0);
    chk("R9 held request acked", int'(ack), 1);
    chk("R9 held request id", int'(ack_id), 2);
    seen_r9 = 1;

    // Pseudo-random sweep with biased strobes
    for (int c = 0; c < 20000; c++) begin
      logic [N-1:0] rq;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      for (int b = 0; b < N; b++) rq[b] = (lf[3*b +: 3] == 3'd0);
      if (lf[17:14] == 4'd0) pr_hold = lf[N+19:20];
      step(rq, pr_hold, lf[28:24] == 5'd0, lf[31:27] == 5'd1,
           lf[13:12] == 2'd0, lf[11:8] == 4'd0, lf[4], lf[7:5] == 3'd0);
    end
    step('0, '0, 0, 0, 0, 0, 0, 0);
    if (!seen_r9) chk("R9 sequence", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule